// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block breaks a vector operation over an arbitrary number of elements into pieces no longer than the machine's maximum vector length of 64. After a start pulse it takes a 16-bit element count and a base index. It then presents a series of chunks to a downstream vector execution unit. Each chunk carries the index of its first element and the value to load into the vector-length register.

If the element count is not a multiple of 64, the leftover piece (count mod 64) is issued first. Every chunk after that is exactly 64 elements long, and each one starts where the previous chunk ended. Each chunk is offered with a valid/ready handshake and stays on the outputs until the consumer accepts it. A completion flag rises once the last chunk has been taken.

A loop compiler would emit the same schedule in software. Here the sequencing is done by hardware, so the execution unit only has to consume chunks.

Top module: `vlen_strip_seq`

## Requirements
- R1: After reset, `chunk_valid` and `done` are both low.
- R2: The first chunk starts at `base_idx`. When `elem_count` mod 64 is non-zero, the first chunk's length is `elem_count` mod 64. It appears on the outputs in the cycle after the accepted `go`.
- R3: When `elem_count` is a non-zero multiple of 64, no zero-length chunk is issued, and the first chunk has length 64.
- R4: Every chunk after the first has length 64. Its start equals the previous start plus the previous length, modulo 2^16.
- R5: The total number of chunks is `elem_count`/64 (integer division), plus one if a remainder exists. The chunk lengths add up to `elem_count`.
- R6: An accepted `go` with `elem_count` equal to 0 issues no chunk. It raises `done` in the following cycle.
- R7: While `chunk_valid` is high and `chunk_ready` is low, `chunk_valid`, `chunk_start` and `chunk_len` hold their values. The sequencer advances only on a cycle where valid and ready are both high.
- R8: A `go` pulse that arrives while a chunk is pending (`chunk_valid` high) is ignored. The chunks that follow are unchanged.
- R9: `done` rises in the cycle after the handshake of the last chunk and stays high until the next accepted `go`, which clears it. `done` is never high together with `chunk_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse; accepted only while no chunk is pending |
| elem_count | input | 16 | Total element count, sampled on an accepted `go` |
| base_idx | input | 16 | Index of the first element, sampled on an accepted `go` |
| chunk_ready | input | 1 | Downstream unit accepts the current chunk |
| chunk_valid | output | 1 | A chunk is presented |
| chunk_start | output | 16 | First element index of the current chunk |
| chunk_len | output | 7 | Vector-length value for the current chunk (1..64) |
| done | output | 1 | Sequence complete; held until the next accepted `go` |

## Verification
Two cases are hard to reach from the ports. The first is a start pulse that lands while a chunk is still waiting for acceptance. The second is a consumer that stalls for a different number of cycles on each chunk. The stimulus sweeps every element count from 0 to 260 and adds a few large and wrapping cases. The downstream responder uses a random ready delay on every chunk. On about half of the runs it injects a start pulse with a different count during a stall, and the chunks that follow must still match the original schedule.

// File: rtl/vss_pkg.sv
package vss_pkg;

  // Length of the leading chunk: the remainder when there is one, else a full chunk.
  function automatic int unsigned head_len(input int unsigned total, input int unsigned mvl);
    int unsigned rmd;
    rmd = total % mvl;
    return (rmd == 0) ? mvl : rmd;
  endfunction

  // Number of chunks a count splits into.
  function automatic int unsigned chunk_total(input int unsigned total, input int unsigned mvl);
    return (total / mvl) + ((total % mvl) != 0 ? 1 : 0);
  endfunction

endpackage

// File: rtl/vss_datapath.sv
module vss_datapath
  import vss_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX_W = 16,
  parameter int MAXVL = 64,
  localparam int LEN_W = $clog2(MAXVL) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] count_in,
  input  logic [IDX_W-1:0] base_in,
  input  logic             pending,
  output logic [IDX_W-1:0] cur_start,
  output logic [LEN_W-1:0] cur_len,
  output logic             is_last,
  output logic             count_zero
);

  logic [CNT_W-1:0] rem_q;
  logic [IDX_W-1:0] start_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] first_len;

  assign first_len  = LEN_W'(head_len(int'(count_in), MAXVL));
  assign count_zero = (count_in == '0);
  assign is_last    = (rem_q == CNT_W'(len_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q   <= '0;
      start_q <= '0;
      len_q   <= '0;
    end else if (load) begin
      rem_q   <= count_in;
      start_q <= base_in;
      len_q   <= first_len;
    end else if (step) begin
      rem_q   <= rem_q - CNT_W'(len_q);
      start_q <= start_q + IDX_W'(len_q);
      len_q   <= LEN_W'(MAXVL);
    end
  end

  assign cur_start = start_q;
  assign cur_len   = len_q;

  assert_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (len_q != '0) && (len_q <= LEN_W'(MAXVL)));

  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step && !is_last && !load |=> (len_q == LEN_W'(MAXVL)) &&
                                   (start_q == $past(start_q + IDX_W'(len_q))));

  assert_remainder_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (rem_q >= CNT_W'(len_q)));

endmodule

// File: rtl/vss_ctrl.sv
module vss_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic ready,
  input  logic is_last,
  input  logic count_zero,
  output logic go_accept,
  output logic xfer,
  output logic valid,
  output logic done
);

  logic valid_q;
  logic done_q;

  assign go_accept = go && !valid_q;
  assign xfer      = valid_q && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (go_accept) begin
      valid_q <= !count_zero;
      done_q  <= count_zero;
    end else if (xfer && is_last) begin
      valid_q <= 1'b0;
      done_q  <= 1'b1;
    end
  end

  assign valid = valid_q;
  assign done  = done_q;

  assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && done_q));

  assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go_accept && count_zero |=> done_q && !valid_q);

  assert_last_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && is_last |=> done_q);

endmodule

// File: rtl/vlen_strip_seq.sv
module vlen_strip_seq #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 16,
  parameter int MAXVL = 64,
  localparam int LEN_W = $clog2(MAXVL) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] elem_count,
  input  logic [IDX_W-1:0] base_idx,
  input  logic             chunk_ready,
  output logic             chunk_valid,
  output logic [IDX_W-1:0] chunk_start,
  output logic [LEN_W-1:0] chunk_len,
  output logic             done
);

  logic go_accept;
  logic xfer;
  logic is_last;
  logic count_zero;
  logic valid_w;

  vss_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .ready      (chunk_ready),
    .is_last    (is_last),
    .count_zero (count_zero),
    .go_accept  (go_accept),
    .xfer       (xfer),
    .valid      (valid_w),
    .done       (done)
  );

  vss_datapath #(
    .CNT_W (CNT_W),
    .IDX_W (IDX_W),
    .MAXVL (MAXVL)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (go_accept),
    .step       (xfer),
    .count_in   (elem_count),
    .base_in    (base_idx),
    .pending    (valid_w),
    .cur_start  (chunk_start),
    .cur_len    (chunk_len),
    .is_last    (is_last),
    .count_zero (count_zero)
  );

  assign chunk_valid = valid_w;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && !chunk_ready |=> chunk_valid && $stable(chunk_start) && $stable(chunk_len));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && go && !chunk_ready |=> !done && $stable(chunk_start));

endmodule

// File: tb/vlen_strip_seq_tb.sv
`timescale 1ns/1ps
module vlen_strip_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [15:0] elem_count = '0;
  logic [15:0] base_idx = '0;
  logic        chunk_ready = 1'b0;
  logic        chunk_valid;
  logic [15:0] chunk_start;
  logic [6:0]  chunk_len;
  logic        done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vlen_strip_seq u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .elem_count  (elem_count),
    .base_idx    (base_idx),
    .chunk_ready (chunk_ready),
    .chunk_valid (chunk_valid),
    .chunk_start (chunk_start),
    .chunk_len   (chunk_len),
    .done        (done)
  );

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic run_seq(input int n, input logic [15:0] base, input bit disturb);
    logic [15:0] exp_start;
    int exp_rem;
    int exp_len;
    int nchunk;
    int sum;
    int dly;
    bit first;
    @(negedge clk);
    elem_count = n[15:0];
    base_idx   = base;
    go         = 1'b1;
    @(negedge clk);
    go = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R6 done after zero count", done, 1);
      chk(chunk_valid == 1'b0, "R6 no chunk for zero count", chunk_valid, 0);
      return;
    end
    chk(done == 1'b0, "R9 done cleared by go", done, 0);
    exp_start = base;
    exp_rem = n;
    first = 1'b1;
    nchunk = 0;
    sum = 0;
    while (exp_rem > 0) begin
      exp_len = (first && (n % 64) != 0) ? (n % 64) : 64;
      dly = $urandom_range(0, 3);
      for (int d = 0; d <= dly; d++) begin
        chunk_ready = (d == dly);
        chk(chunk_valid == 1'b1, "R7 valid held", chunk_valid, 1);
        chk(chunk_start == exp_start, first ? "R2 first start" : "R4 next start",
            chunk_start, exp_start);
        chk(int'(chunk_len) == exp_len,
            first ? ((n % 64) != 0 ? "R2 remainder len" : "R3 full first len") : "R4 full len",
            chunk_len, exp_len);
        if (disturb && d == 0 && dly > 0) begin
          go = 1'b1;
          elem_count = 16'(n + 5);
          base_idx = base + 16'd77;
        end
        @(negedge clk);
        go = 1'b0;
        if (d < dly) chk(done == 1'b0, "R8 busy go ignored", done, 0);
      end
      chunk_ready = 1'b0;
      sum += exp_len;
      nchunk++;
      exp_start = exp_start + 16'(exp_len);
      exp_rem -= exp_len;
      first = 1'b0;
    end
    chk(done == 1'b1, "R9 done after last chunk", done, 1);
    chk(chunk_valid == 1'b0, "R5 no extra chunk", chunk_valid, 0);
    chk(nchunk == (n / 64 + ((n % 64) != 0 ? 1 : 0)) && sum == n, "R5 chunk count and sum",
        nchunk, n / 64 + ((n % 64) != 0 ? 1 : 0));
    @(negedge clk);
    chk(done == 1'b1, "R9 done held", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(chunk_valid == 1'b0, "R1 reset valid", chunk_valid, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(chunk_valid == 1'b0 && done == 1'b0, "R1 idle after reset", chunk_valid, 0);
    for (int n = 0; n <= 260; n++) begin
      run_seq(n, 16'($urandom), n[0]);
    end
    run_seq(4096, 16'h0100, 1'b1);
    run_seq(4097, 16'hFFF0, 1'b1);
    run_seq(65535, 16'h8000, 1'b0);
    run_seq(130, 16'hFFC0, 1'b1);
    run_seq(0, 16'h1234, 1'b0);
    run_seq(64, 16'hFFFF, 1'b1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule